// File: doc/BRIEF.md
# Beam Structure Histogrammer

The block builds a time profile of particle arrival within each beam spill. A beam-start pulse arms two histogram channels. Each channel waits its own programmed offset, measured in 100 ns units. It then walks through a fixed number of bins. Each bin lasts a programmed number of 100 ns units. In every bin the channel counts the rising edges of its selected source. The source is either the OR of the start detectors or the time-of-flight/RPC multiplicity signal, and a select bit per channel makes the choice. Counts from successive spills add into the same bins until the host clears them.

The same beam-start pulse also drives a beam-inhibit output. This output goes high once a programmed beam length has elapsed. It stays high until the next beam-start pulse, so downstream logic can silence itself between spills.

The host reads the bins through a channel select and a bin address, with the data returned one clock later. A read during accumulation returns the value the bin holds at that moment. One clear strobe zeroes both histograms. A 100 ns unit is `TICK_DIV` clock cycles (10 cycles of a 10 ns clock by default). `D` below stands for `TICK_DIV`. `N` stands for `N_BINS`. Clock edges are counted from the edge that samples `beam_start_i` high, which is edge 0.

Top module: `beam_hist_top`

## Requirements
- R1: During and after reset, `beam_inhibit_o` and `rd_data_o` are 0, every bin of both channels reads 0, and no channel counts until a beam-start pulse arrives.
- R2: For a channel with offset `O`, the first clock edge at which a rising edge can be counted is edge `O*D+2` after the beam start. Edges earlier than that are not counted.
- R3: With period `P`, bin `b` takes the edges `O*D+2+b*P*D` through `O*D+1+(b+1)*P*D`. A period of 0 acts as 1.
- R4: Select bit 0 makes a channel count `start_or_i` and ignore `mult_i`. Select bit 1 makes it count `mult_i` and ignore `start_or_i`.
- R5: A rising edge is a clock edge where the source is 1 and was 0 at the previous edge. A level held high counts once, and the history of the source carries across beam starts.
- R6: No edge is counted after the last bin (`N` bins in total) until the next beam start. That beam start restarts from bin 0 and adds to the counts already held.
- R7: A bin count saturates at `2^CNT_W-1` and does not wrap.
- R8: `beam_inhibit_o` falls at the edge that samples a beam start. With beam length `L` it rises at edge `L*D+1` after that beam start, and it stays high until the next beam start.
- R9: `rd_data_o` shows, one edge after it is sampled, the value that bin `rd_addr_i` of channel `rd_chan_i` (0 = A, 1 = B) held before that edge's update. An address of `N` or more reads 0.
- R10: `clear_i` zeroes every bin of both channels at its edge and overrides any count at that edge.
- R11: The two channels share `beam_start_i` and have their own offset, period, select and bins, so neither channel changes the other's histogram.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| beam_start_i | input | 1 | Beam-start pulse, one cycle |
| start_or_i | input | 1 | OR of start detectors |
| mult_i | input | 1 | Time-of-flight/RPC multiplicity |
| chan_src_sel_i | input | 2 | Source select per channel (bit 0 = A) |
| chan_offset_i | input | 2*TIME_W | Offset per channel in 100 ns units |
| chan_period_i | input | 2*TIME_W | Bin period per channel in 100 ns units |
| beam_len_i | input | TIME_W | Beam length in 100 ns units |
| clear_i | input | 1 | Zero all bins |
| rd_chan_i | input | 1 | Read channel (0 = A, 1 = B) |
| rd_addr_i | input | clog2(N_BINS) | Read bin address |
| rd_data_o | output | CNT_W | Read data, one cycle after the address |
| beam_inhibit_o | output | 1 | High from beam end to next beam start |

## Verification
The bench builds the block with `N_BINS=6`, `CNT_W=4`, `TIME_W=8` and `TICK_DIV=2`. At these sizes a whole spill, both bin walks and their ends fit in a few dozen cycles. Saturation is reached with sixteen edges in one long bin, and the unused addresses 6 and 7 can be read to test out-of-range reads. Two channels with different offsets, periods and sources run under the same beam start. Edges fall exactly on the window and bin boundaries, and a second spill exercises accumulation.

// File: rtl/beam_hist_pkg.sv
// Shared constants and types of the beam structure histogrammer.
// Assumes exactly two histogram channels and two candidate sources.
package beam_hist_pkg;
    localparam int NUM_CH   = 2;
    localparam int NUM_SRC  = 2;
    localparam int SRC_START = 0;
    localparam int SRC_MULT  = 1;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_WAIT = 2'd1,
        CH_RUN  = 2'd2
    } chan_state_e;
endpackage

// File: rtl/beam_hist_edge.sv
// Rising-edge detector for the candidate sources.
// Assumes inputs are already synchronous to clk. History is kept across beam starts.
module beam_hist_edge #(
    parameter int N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    output logic [N_SRC-1:0] rise_o
);
    logic [N_SRC-1:0] src_q;

    // Remember each source's value from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_i;
    end

    // A rise is a high level that was low one edge earlier.
    always_comb rise_o = src_i & ~src_q;
endmodule

// File: rtl/beam_hist_inhibit.sv
// Beam-inhibit generator: counts beam length in 100 ns units after a beam start,
// then holds the inhibit high until the next beam start.
// Assumes beam_len_i is stable during a spill.
module beam_hist_inhibit #(
    parameter int TIME_W   = 16,
    parameter int TICK_DIV = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beam_start_i,
    input  logic [TIME_W-1:0] beam_len_i,
    output logic              inhibit_o
);
    localparam int SUB_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic              active_q;
    logic [SUB_W-1:0]  sub_q;
    logic [TIME_W-1:0] unit_q;
    logic              inhibit_q;
    logic              sub_wrap;

    // End of a 100 ns unit.
    always_comb sub_wrap = (sub_q == SUB_W'(TICK_DIV - 1));

    // Time the beam length and set or drop the inhibit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            sub_q     <= '0;
            unit_q    <= '0;
            inhibit_q <= 1'b0;
        end else if (beam_start_i) begin
            active_q  <= 1'b1;
            sub_q     <= '0;
            unit_q    <= '0;
            inhibit_q <= 1'b0;
        end else if (active_q) begin
            if (unit_q == beam_len_i) begin
                inhibit_q <= 1'b1;
                active_q  <= 1'b0;
            end else if (sub_wrap) begin
                sub_q  <= '0;
                unit_q <= unit_q + TIME_W'(1);
            end else begin
                sub_q <= sub_q + SUB_W'(1);
            end
        end
    end

    assign inhibit_o = inhibit_q;
endmodule

// File: rtl/beam_hist_chan.sv
// One histogram channel: waits an offset after beam start, then steps through
// N_BINS bins of a programmed period, counting hits per bin with saturation.
// Assumes offset and period are stable during a spill; period 0 acts as 1.
module beam_hist_chan
    import beam_hist_pkg::*;
#(
    parameter int N_BINS   = 500,
    parameter int CNT_W    = 16,
    parameter int TIME_W   = 16,
    parameter int TICK_DIV = 10,
    parameter int BIN_W    = (N_BINS > 1) ? $clog2(N_BINS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beam_start_i,
    input  logic              clear_i,
    input  logic              hit_i,
    input  logic [TIME_W-1:0] offset_i,
    input  logic [TIME_W-1:0] period_i,
    input  logic [BIN_W-1:0]  rd_addr_i,
    output logic [CNT_W-1:0]  rd_word_o
);
    localparam int             SUB_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [BIN_W:0]   NB      = (BIN_W + 1)'(N_BINS);

    chan_state_e       state_q;
    logic [SUB_W-1:0]  sub_q;
    logic [TIME_W-1:0] unit_q;
    logic [BIN_W-1:0]  bin_q;
    logic [CNT_W-1:0]  mem [N_BINS];

    logic [TIME_W-1:0] per_eff;
    logic              sub_wrap;
    logic              unit_last;
    logic              bin_last;
    logic              count_en;

    // Decode the boundaries of units, bins and the histogram.
    always_comb begin
        per_eff   = (period_i == '0) ? TIME_W'(1) : period_i;
        sub_wrap  = (sub_q == SUB_W'(TICK_DIV - 1));
        unit_last = (unit_q == per_eff - TIME_W'(1));
        bin_last  = (bin_q == BIN_W'(N_BINS - 1));
        count_en  = (state_q == CH_RUN) && hit_i && !beam_start_i;
    end

    // Sequence the offset wait and the walk through the bins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            sub_q   <= '0;
            unit_q  <= '0;
            bin_q   <= '0;
        end else if (beam_start_i) begin
            state_q <= CH_WAIT;
            sub_q   <= '0;
            unit_q  <= '0;
            bin_q   <= '0;
        end else begin
            case (state_q)
                CH_WAIT: begin
                    if (unit_q == offset_i) begin
                        state_q <= CH_RUN;
                        sub_q   <= '0;
                        unit_q  <= '0;
                    end else if (sub_wrap) begin
                        sub_q  <= '0;
                        unit_q <= unit_q + TIME_W'(1);
                    end else begin
                        sub_q <= sub_q + SUB_W'(1);
                    end
                end
                CH_RUN: begin
                    if (sub_wrap) begin
                        sub_q <= '0;
                        if (unit_last) begin
                            unit_q <= '0;
                            if (bin_last) state_q <= CH_IDLE;
                            else          bin_q   <= bin_q + BIN_W'(1);
                        end else begin
                            unit_q <= unit_q + TIME_W'(1);
                        end
                    end else begin
                        sub_q <= sub_q + SUB_W'(1);
                    end
                end
                default: state_q <= CH_IDLE;
            endcase
        end
    end

    // Clear or saturating increment of the current bin.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            for (int i = 0; i < N_BINS; i++) mem[i] <= '0;
        end else if (count_en && (mem[bin_q] != CNT_MAX)) begin
            mem[bin_q] <= mem[bin_q] + CNT_W'(1);
        end
    end

    // Combinational read of one bin; unused addresses read zero.
    always_comb begin
        if ({1'b0, rd_addr_i} < NB) rd_word_o = mem[rd_addr_i];
        else                        rd_word_o = '0;
    end
endmodule

// File: rtl/beam_hist_top.sv
// Beam structure histogrammer top: two channels sharing beam start, per-channel
// source select, a beam-inhibit generator and a registered read port.
// Assumes all inputs are synchronous to clk and beam_start_i is a one-cycle pulse.
module beam_hist_top
    import beam_hist_pkg::*;
#(
    parameter int N_BINS   = 500,
    parameter int CNT_W    = 16,
    parameter int TIME_W   = 16,
    parameter int TICK_DIV = 10,
    parameter int BIN_W    = (N_BINS > 1) ? $clog2(N_BINS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          beam_start_i,
    input  logic                          start_or_i,
    input  logic                          mult_i,
    input  logic [NUM_CH-1:0]             chan_src_sel_i,
    input  logic [NUM_CH-1:0][TIME_W-1:0] chan_offset_i,
    input  logic [NUM_CH-1:0][TIME_W-1:0] chan_period_i,
    input  logic [TIME_W-1:0]             beam_len_i,
    input  logic                          clear_i,
    input  logic                          rd_chan_i,
    input  logic [BIN_W-1:0]              rd_addr_i,
    output logic [CNT_W-1:0]              rd_data_o,
    output logic                          beam_inhibit_o
);
    logic [NUM_SRC-1:0]           src_vec;
    logic [NUM_SRC-1:0]           rise_vec;
    logic [NUM_CH-1:0][CNT_W-1:0] rd_words;
    logic [CNT_W-1:0]             rd_data_q;

    // Gather the candidate sources in a fixed order.
    always_comb begin
        src_vec            = '0;
        src_vec[SRC_START] = start_or_i;
        src_vec[SRC_MULT]  = mult_i;
    end

    beam_hist_edge #(.N_SRC(NUM_SRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_vec),
        .rise_o (rise_vec)
    );

    beam_hist_inhibit #(.TIME_W(TIME_W), .TICK_DIV(TICK_DIV)) u_inhibit (
        .clk          (clk),
        .rst_n        (rst_n),
        .beam_start_i (beam_start_i),
        .beam_len_i   (beam_len_i),
        .inhibit_o    (beam_inhibit_o)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        logic hit;

        // Route the selected source's rising edge to this channel.
        always_comb hit = chan_src_sel_i[ch] ? rise_vec[SRC_MULT] : rise_vec[SRC_START];

        beam_hist_chan #(
            .N_BINS   (N_BINS),
            .CNT_W    (CNT_W),
            .TIME_W   (TIME_W),
            .TICK_DIV (TICK_DIV),
            .BIN_W    (BIN_W)
        ) u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .beam_start_i (beam_start_i),
            .clear_i      (clear_i),
            .hit_i        (hit),
            .offset_i     (chan_offset_i[ch]),
            .period_i     (chan_period_i[ch]),
            .rd_addr_i    (rd_addr_i),
            .rd_word_o    (rd_words[ch])
        );
    end

    // Register the word of the addressed channel.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data_q <= '0;
        else        rd_data_q <= rd_words[rd_chan_i];
    end

    assign rd_data_o = rd_data_q;
endmodule

// File: rtl/beam_hist_chk.sv
// Port-level property checker for the beam structure histogrammer, bound to the top.
// Assumes the same N_BINS and CNT_W as the instance it is bound to.
module beam_hist_chk #(
    parameter int N_BINS = 500,
    parameter int CNT_W  = 16,
    parameter int BIN_W  = (N_BINS > 1) ? $clog2(N_BINS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             beam_start_i,
    input logic             clear_i,
    input logic [BIN_W-1:0] rd_addr_i,
    input logic [CNT_W-1:0] rd_data_o,
    input logic             beam_inhibit_o
);
    localparam logic [BIN_W:0] NB = (BIN_W + 1)'(N_BINS);

    assert_inhibit_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        beam_start_i |=> !beam_inhibit_o);

    assert_inhibit_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (beam_inhibit_o && !beam_start_i) |=> beam_inhibit_o);

    assert_inhibit_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beam_inhibit_o) |-> !$past(beam_start_i));

    assert_rd_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, rd_addr_i} >= NB) |=> (rd_data_o == '0));

    assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> ##1 (rd_data_o == '0));
endmodule

bind beam_hist_top beam_hist_chk #(.N_BINS(N_BINS), .CNT_W(CNT_W), .BIN_W(BIN_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .beam_start_i   (beam_start_i),
    .clear_i        (clear_i),
    .rd_addr_i      (rd_addr_i),
    .rd_data_o      (rd_data_o),
    .beam_inhibit_o (beam_inhibit_o)
);

// File: tb/beam_hist_top_tb.sv
module beam_hist_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB   = 6;
    localparam int CW   = 4;
    localparam int TW   = 8;
    localparam int TD   = 2;
    localparam int BW   = 3;
    localparam int CMAX = 15;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                beam_start = 1'b0;
    logic                start_or = 1'b0;
    logic                mult = 1'b0;
    logic [1:0]          src_sel = '0;
    logic [1:0][TW-1:0]  offset = '0;
    logic [1:0][TW-1:0]  period = '0;
    logic [TW-1:0]       beam_len = '0;
    logic                clear = 1'b0;
    logic                rd_chan = 1'b0;
    logic [BW-1:0]       rd_addr = '0;
    logic [CW-1:0]       rd_data;
    logic                inhibit;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    beam_hist_top #(.N_BINS(NB), .CNT_W(CW), .TIME_W(TW), .TICK_DIV(TD)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .beam_start_i   (beam_start),
        .start_or_i     (start_or),
        .mult_i         (mult),
        .chan_src_sel_i (src_sel),
        .chan_offset_i  (offset),
        .chan_period_i  (period),
        .beam_len_i     (beam_len),
        .clear_i        (clear),
        .rd_chan_i      (rd_chan),
        .rd_addr_i      (rd_addr),
        .rd_data_o      (rd_data),
        .beam_inhibit_o (inhibit)
    );

    // Behavioural reference model, updated at every rising edge.
    int  m_cnt [2][NB];
    int  m_k   [2];
    bit  m_act [2];
    int  m_ik;
    bit  m_iact;
    bit  m_inh;
    int  m_rd;
    bit  m_ps, m_pm;
    bit  seen = 0;

    always @(posedge clk) begin
        seen = 1;
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_act[c] = 0; m_k[c] = 0;
                for (int b = 0; b < NB; b++) m_cnt[c][b] = 0;
            end
            m_ik = 0; m_iact = 0; m_inh = 0; m_rd = 0; m_ps = 0; m_pm = 0;
        end else begin
            bit rs, rm;
            m_rd = (int'(rd_addr) < NB) ? m_cnt[rd_chan][int'(rd_addr)] : 0;
            rs = start_or && !m_ps;
            rm = mult && !m_pm;
            if (clear)
                for (int c = 0; c < 2; c++)
                    for (int b = 0; b < NB; b++) m_cnt[c][b] = 0;
            if (beam_start) begin
                for (int c = 0; c < 2; c++) begin m_act[c] = 1; m_k[c] = 0; end
                m_ik = 0; m_iact = 1; m_inh = 0;
            end else begin
                for (int c = 0; c < 2; c++) begin
                    if (m_act[c]) begin
                        int first, per, blen, r;
                        bit hit;
                        m_k[c]++;
                        first = int'(offset[c]) * TD + 2;
                        per   = (period[c] == 0) ? 1 : int'(period[c]);
                        blen  = per * TD;
                        r     = m_k[c] - first;
                        hit   = src_sel[c] ? rm : rs;
                        if (!clear && hit && m_k[c] >= first && r < NB * blen)
                            if (m_cnt[c][r / blen] < CMAX) m_cnt[c][r / blen]++;
                    end
                end
                if (m_iact) begin
                    m_ik++;
                    if (m_ik >= int'(beam_len) * TD + 1) begin m_inh = 1; m_iact = 0; end
                end
            end
            m_ps = start_or;
            m_pm = mult;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (seen && rst_n) begin
            check("R9 readback vs model", int'(rd_data), m_rd);
            check("R8 inhibit vs model", int'(inhibit), int'(m_inh));
        end
    end

    task automatic rd(input bit ch, input int addr, input int exp, input string tag);
        rd_chan = ch;
        rd_addr = BW'(addr);
        @(negedge clk);
        check(tag, int'(rd_data), exp);
    endtask

    task automatic beam();
        beam_start = 1'b1;
        @(negedge clk);
        beam_start = 1'b0;
    endtask

    // Drive per-edge source patterns: bit t is the level sampled at edge t.
    task automatic run_beam(input logic [63:0] ps, input logic [63:0] pm, input bit chk_inh);
        beam();
        for (int t = 1; t < 46; t++) begin
            start_or = ps[t];
            mult     = pm[t];
            if (chk_inh && t == 11) check("R8 inhibit low before L*D+1", int'(inhibit), 0);
            if (chk_inh && t == 12) check("R8 inhibit high after L*D+1", int'(inhibit), 1);
            @(negedge clk);
        end
        start_or = 1'b0;
        mult     = 1'b0;
    endtask

    initial begin
        logic [63:0] ps, pm;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 inhibit after reset", int'(inhibit), 0);
        check("R1 rd_data after reset", int'(rd_data), 0);
        for (int b = 0; b < NB; b++) begin
            rd(1'b0, b, 0, "R1 A bin zero");
            rd(1'b1, b, 0, "R1 B bin zero");
        end

        // Spill 1: A offset 1 period 1 start source; B offset 0 period 2 mult source.
        offset[0] = 8'd1; period[0] = 8'd1; src_sel[0] = 1'b0;
        offset[1] = 8'd0; period[1] = 8'd2; src_sel[1] = 1'b1;
        beam_len  = 8'd5;
        ps = '0; pm = '0;
        ps[3] = 1; ps[4] = 1; ps[6] = 1; ps[8] = 1; ps[9] = 1; ps[11] = 1;
        ps[15] = 1; ps[16] = 1; ps[18] = 1;
        pm[2] = 1; pm[5] = 1; pm[7] = 1; pm[10] = 1; pm[25] = 1; pm[28] = 1;
        run_beam(ps, pm, 1'b1);
        rd(1'b0, 0, 0, "R2 A edge before window not counted");
        rd(1'b0, 1, 1, "R5 A held level counted once");
        rd(1'b0, 2, 1, "R3 A bin2");
        rd(1'b0, 3, 1, "R3 A bin3 second edge of bin");
        rd(1'b0, 4, 0, "R4 A ignores mult");
        rd(1'b0, 5, 1, "R6 A last bin, later edge dropped");
        rd(1'b1, 0, 2, "R2 B first window edge counted");
        rd(1'b1, 1, 1, "R11 B bin1");
        rd(1'b1, 2, 1, "R3 B bin boundary");
        rd(1'b1, 3, 0, "R4 B ignores start");
        rd(1'b1, 5, 1, "R6 B last bin, later edge dropped");
        rd(1'b0, 6, 0, "R9 out-of-range address");
        rd(1'b1, 7, 0, "R9 out-of-range address");

        // Spill 2: accumulation into existing bins.
        ps = '0; pm = '0;
        ps[4] = 1;
        run_beam(ps, pm, 1'b1);
        rd(1'b0, 0, 1, "R6 A bin0 after second spill");
        rd(1'b0, 1, 1, "R6 A bin1 kept");
        rd(1'b1, 0, 2, "R11 B untouched by A hit");

        // Clear, then saturate one long bin.
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        for (int b = 0; b < NB; b++) begin
            rd(1'b0, b, 0, "R10 A cleared");
            rd(1'b1, b, 0, "R10 B cleared");
        end
        offset[0] = 8'd0; period[0] = 8'd20;
        ps = '0; pm = '0;
        for (int t = 2; t <= 40; t += 2) ps[t] = 1;
        run_beam(ps, pm, 1'b0);
        rd(1'b0, 0, CMAX, "R7 saturation");
        rd(1'b0, 1, 0, "R7 next bin empty");
        rd(1'b1, 0, 0, "R4 B mult source silent");

        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule